// File: doc/BRIEF.md
# Local Two-Stage Tick Timer

This block is a per-core event timer built from two counters in series. The first stage is a prescaler. It reloads from a programmable tick-count buffer and emits one tick every (buffer + 1) input clocks. The second stage is a 31-bit interrupt counter. It moves one step toward zero on each tick and raises an event when it passes from 1 to 0. Software chooses between two behaviours. In repeat mode the interrupt counter reloads from its buffer and keeps firing. In one-shot mode it stops at zero until it is loaded again.

All state is reached over a simple 32-bit write/read bus. The bus also carries a sticky write-status word, which software polls after each buffer or control write and clears by writing 1. The interrupt counter only takes a new value when the count word is written with its top bit set. A write with that bit clear changes only the buffer used for later reloads.

Top module: `lcl_tick_timer`

## Requirements
- R1: After synchronous reset, every register reads 0 (tick buffer 0x00, count buffer 0x08, control 0x20, status 0x30, enable 0x34, write status 0x40), and `irq` is 0.
- R2: With control bit 0 set, the prescaler emits one tick every N+1 clocks, where N is the value last written to offset 0x00. A write to 0x00 also restarts the prescaler from N.
- R3: A write to 0x08 stores bits 30:0 as the reload buffer, which reads back with bit 31 as 0. The active interrupt counter is loaded with bits 30:0 only when bit 31 of the written word is 1.
- R4: When control bits 0 and 1 are both set and the active count is C, status bit 0 (offset 0x30) sets C*(N+1) clocks after the control write. `irq` rises one clock later.
- R5: With control bit 2 (repeat) set, the counter reloads from the buffer on each expiry and raises another event every buffer*(N+1) clocks.
- R6: With control bit 2 clear, the counter holds 0 after expiry and raises no further event until it is loaded again.
- R7: Clearing control bit 0 or bit 1 freezes the corresponding counter. Setting the bit again resumes from the held value.
- R8: Status bit 0 clears only when 1 is written to bit 0 at offset 0x30. A write of 0 leaves it set.
- R9: `irq` is the registered AND of status bit 0 and enable bit 0 (offset 0x34). With enable clear, status still sets but `irq` stays low.
- R10: Write status (offset 0x40) sets bit 0 on a 0x00 write, bit 1 on a 0x08 write and bit 3 on a 0x20 write. Writing 1 to a bit clears only that bit.
- R11: Control bits 2:0 read back at offset 0x20 as written. Read data appears on `bus_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker watches several properties on every cycle. It confirms that `irq` never rises without enabled status in the cycle before. It confirms that status falls only after a write-1-to-clear. It checks that a stopped counter keeps its value, that an idle interrupt counter at zero stays there unless an update write arrives, and that a control write always leaves write-status bit 3 set. The directed scenarios are needed for the behaviour that spans many cycles: the exact expiry latency as a function of both buffers, the repeat period, resuming after a freeze, and the difference between buffer-only and update writes.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  localparam logic [7:0] OFF_TCB = 8'h00;
  localparam logic [7:0] OFF_ICB = 8'h08;
  localparam logic [7:0] OFF_CTL = 8'h20;
  localparam logic [7:0] OFF_IST = 8'h30;
  localparam logic [7:0] OFF_IEN = 8'h34;
  localparam logic [7:0] OFF_WST = 8'h40;

  localparam int CTL_TICK_RUN = 0;
  localparam int CTL_INT_RUN  = 1;
  localparam int CTL_REPEAT   = 2;

  localparam int WS_TCB = 0;
  localparam int WS_ICB = 1;
  localparam int WS_CTL = 3;
endpackage

// File: rtl/ltt_regs.sv
module ltt_regs
  import ltt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [TICK_W-1:0] tcb_q,
  output logic              tcb_wr,
  output logic [ICNT_W-1:0] ibuf_q,
  output logic              icnt_upd,
  output logic [2:0]        ctl_q,
  output logic              ist_q,
  output logic              ien_q,
  output logic [3:0]        wst_q,
  output logic [DATA_W-1:0] rdata
);
  logic hit_tcb, hit_icb, hit_ctl, hit_ist, hit_ien, hit_wst;
  logic [3:0] wst_set;

  assign hit_tcb  = bus_wr && (bus_addr == ADDR_W'(OFF_TCB));
  assign hit_icb  = bus_wr && (bus_addr == ADDR_W'(OFF_ICB));
  assign hit_ctl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
  assign hit_ist  = bus_wr && (bus_addr == ADDR_W'(OFF_IST));
  assign hit_ien  = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign hit_wst  = bus_wr && (bus_addr == ADDR_W'(OFF_WST));
  assign tcb_wr   = hit_tcb;
  assign icnt_upd = hit_icb && bus_wdata[DATA_W-1];

  always_comb begin
    wst_set         = '0;
    wst_set[WS_TCB] = hit_tcb;
    wst_set[WS_ICB] = hit_icb;
    wst_set[WS_CTL] = hit_ctl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcb_q  <= '0;
      ibuf_q <= '0;
      ctl_q  <= '0;
      ist_q  <= 1'b0;
      ien_q  <= 1'b0;
      wst_q  <= '0;
      rdata  <= '0;
    end else begin
      if (hit_tcb) tcb_q  <= bus_wdata[TICK_W-1:0];
      if (hit_icb) ibuf_q <= bus_wdata[ICNT_W-1:0];
      if (hit_ctl) ctl_q  <= bus_wdata[2:0];
      if (hit_ien) ien_q  <= bus_wdata[0];
      if (expire)
        ist_q <= 1'b1;
      else if (hit_ist && bus_wdata[0])
        ist_q <= 1'b0;
      wst_q <= (wst_q & ~({4{hit_wst}} & bus_wdata[3:0])) | wst_set;
      case (bus_addr)
        ADDR_W'(OFF_TCB): rdata <= DATA_W'(tcb_q);
        ADDR_W'(OFF_ICB): rdata <= DATA_W'(ibuf_q);
        ADDR_W'(OFF_CTL): rdata <= DATA_W'(ctl_q);
        ADDR_W'(OFF_IST): rdata <= DATA_W'(ist_q);
        ADDR_W'(OFF_IEN): rdata <= DATA_W'(ien_q);
        ADDR_W'(OFF_WST): rdata <= DATA_W'(wst_q);
        default:          rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ltt_prescaler.sv
module ltt_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  input  logic [TICK_W-1:0] reload_val,
  output logic              tick,
  output logic [TICK_W-1:0] cnt
);
  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (run) begin
      if (cnt == '0)
        cnt <= reload_val;
      else
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ltt_intcnt.sv
module ltt_intcnt #(
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              repeat_en,
  input  logic              upd,
  input  logic [ICNT_W-1:0] upd_val,
  input  logic [ICNT_W-1:0] buf_val,
  output logic              expire,
  output logic [ICNT_W-1:0] cnt
);
  logic step;

  assign step   = run && tick && (cnt != '0);
  assign expire = step && (cnt == ICNT_W'(1)) && !upd;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (upd)
      cnt <= upd_val;
    else if (step) begin
      if (cnt == ICNT_W'(1))
        cnt <= repeat_en ? buf_val : '0;
      else
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lcl_tick_timer.sv
module lcl_tick_timer
  import ltt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int DATA_W = 32;

  logic [TICK_W-1:0] tcb_q, tick_cnt;
  logic              tcb_wr, icnt_upd, tick, expire;
  logic [ICNT_W-1:0] ibuf_q, int_cnt;
  logic [2:0]        ctl_q;
  logic              ist_q, ien_q;
  logic [3:0]        wst_q;

  ltt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W), .ICNT_W(ICNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .tcb_q(tcb_q), .tcb_wr(tcb_wr),
    .ibuf_q(ibuf_q), .icnt_upd(icnt_upd), .ctl_q(ctl_q), .ist_q(ist_q),
    .ien_q(ien_q), .wst_q(wst_q), .rdata(bus_rdata)
  );

  ltt_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q[CTL_TICK_RUN]), .load(tcb_wr),
    .load_val(bus_wdata[TICK_W-1:0]), .reload_val(tcb_q),
    .tick(tick), .cnt(tick_cnt)
  );

  ltt_intcnt #(.ICNT_W(ICNT_W)) u_int (
    .clk(clk), .rst(rst), .run(ctl_q[CTL_INT_RUN]), .tick(tick),
    .repeat_en(ctl_q[CTL_REPEAT]), .upd(icnt_upd),
    .upd_val(bus_wdata[ICNT_W-1:0]), .buf_val(ibuf_q),
    .expire(expire), .cnt(int_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ist_q && ien_q;
  end
endmodule

// File: rtl/lcl_tick_timer_chk.sv
module lcl_tick_timer_chk
  import ltt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TICK_W = 32,
  parameter int ICNT_W = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              ist_q,
  input logic              ien_q,
  input logic [2:0]        ctl_q,
  input logic [3:0]        wst_q,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [ICNT_W-1:0] int_cnt
);
  logic wr_tcb, wr_upd, wr_ctl, wr_clr;
  assign wr_tcb = bus_wr && (bus_addr == ADDR_W'(OFF_TCB));
  assign wr_upd = bus_wr && (bus_addr == ADDR_W'(OFF_ICB)) && bus_wdata[31];
  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
  assign wr_clr = bus_wr && (bus_addr == ADDR_W'(OFF_IST)) && bus_wdata[0];

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ist_q && ien_q));

  p_status_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ist_q) |-> $past(wr_clr));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (int_cnt == '0 && !wr_upd) |=> (int_cnt == '0));

  p_tick_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_TICK_RUN] && !wr_tcb) |=> $stable(tick_cnt));

  p_int_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_INT_RUN] && !wr_upd) |=> $stable(int_cnt));

  p_ctl_wstat_r10: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> wst_q[WS_CTL]);
endmodule

bind lcl_tick_timer lcl_tick_timer_chk #(
  .ADDR_W(ADDR_W), .TICK_W(TICK_W), .ICNT_W(ICNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ist_q(ist_q), .ien_q(ien_q),
  .ctl_q(ctl_q), .wst_q(wst_q), .tick_cnt(tick_cnt), .int_cnt(int_cnt)
);

// File: tb/lcl_tick_timer_test.sv
module lcl_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lcl_tick_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int maxc, output int k);
    k = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); #1;
      if (irq) begin k = i; break; end
    end
  endtask

  task automatic arm(input int tcb, input int icb, input logic [2:0] ctl);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h00, tcb);
    wr(8'h08, 32'h8000_0000 | icb);
    wr(8'h34, 32'h1);
    wr(8'h20, {29'd0, ctl});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq, 0);
    rd(8'h00, d); chk("R1 tcb", d, 0);
    rd(8'h08, d); chk("R1 icb", d, 0);
    rd(8'h20, d); chk("R1 ctl", d, 0);
    rd(8'h30, d); chk("R1 status", d, 0);
    rd(8'h34, d); chk("R1 enable", d, 0);
    rd(8'h40, d); chk("R1 wstat", d, 0);
  endtask

  task automatic t_wstat;
    logic [31:0] d;
    wr(8'h00, 32'h3); rd(8'h40, d); chk("R10 after tcb", d, 32'h1);
    wr(8'h08, 32'h7); rd(8'h40, d); chk("R10 after icb", d, 32'h3);
    wr(8'h20, 32'h4); rd(8'h40, d); chk("R10 after ctl", d, 32'hB);
    rd(8'h20, d); chk("R11 ctl readback", d, 32'h4);
    wr(8'h40, 32'h2); rd(8'h40, d); chk("R10 clear bit1 only", d, 32'h9);
    wr(8'h40, 32'hF); rd(8'h40, d); chk("R10 clear all", d, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_latency(input int tcb, input int icb);
    int k;
    arm(tcb, icb, 3'b011);
    wait_irq(icb * (tcb + 1) + 20, k);
    chk($sformatf("R4 R2 latency tcb=%0d icb=%0d", tcb, icb), k, icb * (tcb + 1) + 1);
  endtask

  task automatic t_repeat;
    int k;
    arm(1, 3, 3'b111);
    wait_irq(40, k); chk("R5 first event", k, 7);
    wr(8'h30, 32'h1);
    @(posedge clk); #1;
    chk("R8 irq low after clear", irq, 0);
    wait_irq(40, k); chk("R5 second event", k, 4);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_oneshot_and_update;
    int k;
    logic [31:0] d;
    arm(0, 2, 3'b011);
    wait_irq(20, k); chk("R4 one-shot event", k, 3);
    wr(8'h30, 32'h0); rd(8'h30, d); chk("R8 write 0 keeps status", d, 1);
    wr(8'h30, 32'h1); rd(8'h30, d); chk("R8 write 1 clears", d, 0);
    repeat (30) @(posedge clk); #1;
    rd(8'h30, d); chk("R6 no second event", d, 0);
    wr(8'h08, 32'h5);
    repeat (20) @(posedge clk); #1;
    rd(8'h30, d); chk("R3 buffer-only write no reload", d, 0);
    rd(8'h08, d); chk("R3 buffer readback", d, 5);
    wr(8'h08, 32'h8000_0005);
    rd(8'h08, d); chk("R3 update bit reads 0", d, 5);
    wait_irq(20, k); chk("R3 update loads counter", k, 5);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_freeze;
    int k;
    logic [31:0] d;
    arm(0, 10, 3'b011);
    repeat (3) @(posedge clk);
    wr(8'h20, 32'h0);
    repeat (20) @(posedge clk); #1;
    chk("R7 frozen no irq", irq, 0);
    rd(8'h30, d); chk("R7 frozen no status", d, 0);
    wr(8'h20, 32'h3);
    wait_irq(20, k); chk("R7 resume from held count", k, 7);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    arm(0, 2, 3'b011);
    wr(8'h34, 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (irq) begin n_bad++; $display("FAIL R9: actual irq 1 expected 0"); end
    end
    n_chk++;
    rd(8'h30, d); chk("R9 status set while masked", d, 1);
    wr(8'h34, 32'h1);
    @(posedge clk); #1;
    chk("R9 irq after enable", irq, 1);
    wr(8'h20, 32'h0);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_wstat();
    t_latency(0, 5);
    t_latency(1, 3);
    t_latency(4, 2);
    t_repeat();
    t_oneshot_and_update();
    t_freeze();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule